// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recently used page mappings and turns a 32-bit virtual address into a 32-bit physical address in a single registered step. Pages are 4 KB. The upper 20 bits of the virtual address (the virtual page number) are compared against every stored slot at once. The low 12 bits are carried across unchanged and appended to the stored 20-bit frame number. Each slot is tagged with an 8-bit address-space identifier. A slot marked global matches for any identifier.

Each slot carries five flags: present, read allowed, write allowed, dirty and global. A lookup that finds a slot reports a hit. It then either delivers the physical address or raises one of three fault codes: page absent, access denied, or store to a clean page. A lookup that finds nothing reports a miss. An external agent then supplies the mapping through the refill port. Refill places the mapping in a fixed order: it overwrites a slot that already holds the same page, otherwise it takes the lowest empty slot, and otherwise it takes the slot named by a free-running 4-bit shift register. A flush input clears every slot, or only the non-global slots of one address space, in one cycle.

Top module: `tlb_xlat`

## Requirements
- R1: After synchronous reset every slot is empty, all response outputs are 0, and the first lookup misses.
- R2: The response to a lookup with `lk_req`=1 appears on the outputs exactly one clock edge later with `rs_valid`=1. A cycle with `lk_req`=0 gives `rs_valid`, `rs_hit`, `rs_miss`, `rs_fault` and `rs_paddr` all 0 on the next edge.
- R3: A slot matches when it is occupied, its page number equals `lk_vaddr[31:12]`, and either its identifier equals `lk_asid` or its global flag is set.
- R4: On a hit with fault code 0, `rs_paddr` is {stored frame number, `lk_vaddr[11:0]`}. In every other case `rs_paddr` is 0.
- R5: On a hit, `rs_fault` is 1 if the present flag is clear. Otherwise it is 2 if the access is denied (a store with write-allowed clear, or a load with read-allowed clear). Otherwise it is 3 for a store whose dirty flag is clear. Otherwise it is 0. The checks are taken in that priority order.
- R6: On a miss, `rs_miss`=1, `rs_hit`=0, `rs_fault`=0 and `rs_paddr`=0.
- R7: With `rf_we`=1 the mapping is written into the first slot that already matches the refill page. A slot matches the refill page when its page number is equal and the identifiers are equal or either side is global. If no slot matches, the mapping goes into the lowest-numbered empty slot. `rf_flags` bit 0 = present, bit 1 = read allowed, bit 2 = write allowed, bit 3 = dirty, bit 4 = global.
- R8: When every slot is occupied and none matches, the refill overwrites the slot whose index equals the current state of a 4-bit shift register. The register loads 1 on reset and shifts left each clock, feeding back bit3 XOR bit2.
- R9: A flush with `fl_all`=1 empties every slot. A flush with `fl_all`=0 empties only the non-global slots whose identifier equals `fl_asid`. The flush takes effect on the edge that samples it.
- R10: When a flush and a refill arrive in the same cycle, the refill slot is chosen from the contents before the flush, and the refilled mapping survives the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the access |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| rs_valid | output | 1 | Response present this cycle |
| rs_hit | output | 1 | A slot matched |
| rs_miss | output | 1 | No slot matched |
| rs_fault | output | 2 | 0 none, 1 absent, 2 denied, 3 clean-page store |
| rs_paddr | output | 32 | Physical address, 0 unless a clean hit |
| rf_we | input | 1 | Refill write strobe |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_asid | input | 8 | Refill identifier |
| rf_pfn | input | 20 | Refill physical frame number |
| rf_flags | input | 5 | Refill flags (encoding in R7) |
| fl_req | input | 1 | Flush strobe |
| fl_all | input | 1 | 1 flushes all slots, 0 flushes by identifier |
| fl_asid | input | 8 | Identifier for a selective flush |

## Verification
The lookup result is registered, so it is due one rising edge after the cycle that holds `lk_req`. The bench drives each request on a falling edge and reads the outputs on the next falling edge, which is exactly one edge later. Refill and flush strobes change the slot contents on the edge that samples them, so the bench only issues the following lookup a cycle later. The bench keeps its own copy of the shift register, stepped on the same edges from the reset seed. It reads that copy when it drives a refill, which tells it which slot a full buffer will give up.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VPN_W  = 20;
    localparam int PFN_W  = 20;
    localparam int ASID_W = 8;
    localparam int OFF_W  = 12;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int FLAG_W = 5;

    // flag word: bit4 global, bit3 dirty, bit2 write ok, bit1 read ok, bit0 present
    typedef struct packed {
        logic glob;
        logic dirty;
        logic wr_ok;
        logic rd_ok;
        logic present;
    } pte_flags_t;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
    } tag_t;

    typedef struct packed {
        logic             occ;
        tag_t             tag;
        logic [PFN_W-1:0] pfn;
        pte_flags_t       fl;
    } slot_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PERM   = 2'd2,
        FLT_CLEAN  = 2'd3
    } fault_e;

    // feedback taps for a left-shifting maximal-length register
    function automatic logic [7:0] lfsr_taps(input int w);
        case (w)
            2:       return 8'h03;
            3:       return 8'h06;
            4:       return 8'h0C;
            5:       return 8'h14;
            6:       return 8'h30;
            7:       return 8'h60;
            8:       return 8'hB8;
            default: return 8'h0C;
        endcase
    endfunction

    function automatic fault_e judge(input pte_flags_t f, input logic is_store);
        if (!f.present)
            return FLT_ABSENT;
        else if (is_store ? !f.wr_ok : !f.rd_ok)
            return FLT_PERM;
        else if (is_store && !f.dirty)
            return FLT_CLEAN;
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
    import tlb_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] TAPS = W'(lfsr_taps(W));

    logic fb;
    assign fb = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (rst)
            state <= W'(1);
        else
            state <= {state[W-2:0], fb};
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  slot_t                  slots [N],
    input  tag_t                   key,
    input  logic                   wild,
    output logic                   any,
    output logic [$clog2(N)-1:0]   first
);
    localparam int IW = $clog2(N);

    logic [N-1:0] hits;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = slots[g].occ
                      && (slots[g].tag.vpn == key.vpn)
                      && (wild || slots[g].fl.glob || (slots[g].tag.asid == key.asid));
    end

    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) first = IW'(i);
        end
    end

    assign any = |hits;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 16
) (
    input  logic [N-1:0]           occ,
    input  logic                   hit_any,
    input  logic [$clog2(N)-1:0]   hit_idx,
    input  logic [$clog2(N)-1:0]   rnd,
    output logic [$clog2(N)-1:0]   pick
);
    localparam int IW = $clog2(N);

    logic          free_any;
    logic [IW-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
        if (hit_any)
            pick = hit_idx;
        else if (free_any)
            pick = free_idx;
        else
            pick = rnd;
    end
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_miss,
    output logic [1:0]        rs_fault,
    output logic [PA_W-1:0]   rs_paddr,
    input  logic              rf_we,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [FLAG_W-1:0] rf_flags,
    input  logic              fl_req,
    input  logic              fl_all,
    input  logic [ASID_W-1:0] fl_asid
);
    localparam int IW = $clog2(ENTRIES);

    slot_t              tab [ENTRIES];
    logic [ENTRIES-1:0] occ_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_occ
        assign occ_vec[g] = tab[g].occ;
    end

    // lookup side
    tag_t          lk_key;
    logic          lk_any;
    logic [IW-1:0] lk_first;
    slot_t         lk_sel;
    fault_e        lk_flt;

    assign lk_key = '{asid: lk_asid, vpn: lk_vaddr[VA_W-1:OFF_W]};

    tlb_match #(.N(ENTRIES)) u_lk_match (
        .slots (tab),
        .key   (lk_key),
        .wild  (1'b0),
        .any   (lk_any),
        .first (lk_first)
    );

    assign lk_sel = tab[lk_first];
    assign lk_flt = judge(lk_sel.fl, lk_write);

    // refill side
    tag_t          rf_key;
    pte_flags_t    rf_fl;
    logic          rf_any;
    logic [IW-1:0] rf_first;
    logic [IW-1:0] rnd_idx;
    logic [IW-1:0] victim;

    assign rf_key = '{asid: rf_asid, vpn: rf_vpn};
    assign rf_fl  = pte_flags_t'(rf_flags);

    tlb_match #(.N(ENTRIES)) u_rf_match (
        .slots (tab),
        .key   (rf_key),
        .wild  (rf_fl.glob),
        .any   (rf_any),
        .first (rf_first)
    );

    tlb_lfsr #(.W(IW)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (rnd_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .occ     (occ_vec),
        .hit_any (rf_any),
        .hit_idx (rf_first),
        .rnd     (rnd_idx),
        .pick    (victim)
    );

    // slot storage: flush first, refill last so a same-cycle refill survives
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tab[i].occ <= 1'b0;
        end else begin
            if (fl_req) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (fl_all || (!tab[i].fl.glob && tab[i].tag.asid == fl_asid))
                        tab[i].occ <= 1'b0;
                end
            end
            if (rf_we)
                tab[victim] <= '{occ: 1'b1, tag: rf_key, pfn: rf_pfn, fl: rf_fl};
        end
    end

    // registered response
    logic lk_found;
    assign lk_found = lk_req && lk_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_miss  <= 1'b0;
            rs_fault <= FLT_NONE;
            rs_paddr <= '0;
        end else begin
            rs_valid <= lk_req;
            rs_hit   <= lk_found;
            rs_miss  <= lk_req && !lk_any;
            rs_fault <= lk_found ? lk_flt : FLT_NONE;
            rs_paddr <= (lk_found && lk_flt == FLT_NONE)
                      ? {lk_sel.pfn, lk_vaddr[OFF_W-1:0]} : '0;
        end
    end
endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_req,
    input logic             lk_write,
    input logic [OFF_W-1:0] lk_off,
    input logic             fl_req,
    input logic             fl_all,
    input logic             rf_we,
    input logic             rs_valid,
    input logic             rs_hit,
    input logic             rs_miss,
    input logic [1:0]       rs_fault,
    input logic [PA_W-1:0]  rs_paddr,
    input logic [N-1:0]     occ
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (occ == '0 && !rs_valid));

    // R2
    resp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rs_valid == $past(lk_req)));

    // R6
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rs_valid |-> (rs_hit != rs_miss));

    // R6
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rs_miss |-> (rs_fault == 2'd0 && rs_paddr == '0));

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rs_hit && rs_fault == 2'd0) |-> (rs_paddr[OFF_W-1:0] == $past(lk_off)));

    // R5
    clean_store_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rs_fault == 2'd3) |-> $past(lk_write));

    // R9
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fl_req && fl_all && !rf_we)) |-> (occ == '0));
endmodule

bind tlb_xlat tlb_xlat_chk #(.N(ENTRIES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_req   (lk_req),
    .lk_write (lk_write),
    .lk_off   (lk_vaddr[tlb_pkg::OFF_W-1:0]),
    .fl_req   (fl_req),
    .fl_all   (fl_all),
    .rf_we    (rf_we),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_miss  (rs_miss),
    .rs_fault (rs_fault),
    .rs_paddr (rs_paddr),
    .occ      (occ_vec)
);

// File: tb/tlb_xlat_test.sv
`timescale 1ns/1ps
module tlb_xlat_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        rs_valid, rs_hit, rs_miss;
    logic [1:0]  rs_fault;
    logic [31:0] rs_paddr;
    logic        rf_we = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [7:0]  rf_asid = '0;
    logic [19:0] rf_pfn = '0;
    logic [4:0]  rf_flags = '0;
    logic        fl_req = 1'b0;
    logic        fl_all = 1'b0;
    logic [7:0]  fl_asid = '0;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [3:0] lf_m;

    always #4 clk = ~clk;

    tlb_xlat uut (.*);

    // shift-register model from R8
    always @(posedge clk) begin
        if (rst) lf_m <= 4'd1;
        else     lf_m <= {lf_m[2:0], lf_m[3] ^ lf_m[2]};
    end

    typedef struct packed {
        logic        op;    // 1 refill, 0 lookup
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic        wr;
        logic [4:0]  fl;
        logic [19:0] pfn;
        logic        ehit;
        logic [1:0]  eflt;
    } vec_t;

    localparam int TN = 23;
    // flags: 1 present, 2 read, 4 write, 8 dirty, 16 global
    localparam vec_t TBL [TN] = '{
        '{1'b1, 20'h00010, 8'd3, 1'b0, 5'h0F, 20'h0AAAA, 1'b0, 2'd0},
        '{1'b1, 20'h00011, 8'd3, 1'b0, 5'h03, 20'h0BBBB, 1'b0, 2'd0},
        '{1'b1, 20'h00012, 8'd3, 1'b0, 5'h07, 20'h0CCCC, 1'b0, 2'd0},
        '{1'b1, 20'h00013, 8'd3, 1'b0, 5'h00, 20'h00000, 1'b0, 2'd0},
        '{1'b1, 20'h00020, 8'd0, 1'b0, 5'h1F, 20'h12345, 1'b0, 2'd0},
        '{1'b1, 20'h00030, 8'd5, 1'b0, 5'h0F, 20'h54321, 1'b0, 2'd0},
        '{1'b1, 20'h00014, 8'd3, 1'b0, 5'h0D, 20'h0DDDD, 1'b0, 2'd0},
        '{1'b0, 20'h00010, 8'd3, 1'b0, 5'h00, 20'h0AAAA, 1'b1, 2'd0},
        '{1'b0, 20'h00010, 8'd3, 1'b1, 5'h00, 20'h0AAAA, 1'b1, 2'd0},
        '{1'b0, 20'h00010, 8'd4, 1'b0, 5'h00, 20'h00000, 1'b0, 2'd0}, // R3 other asid
        '{1'b0, 20'h00011, 8'd3, 1'b1, 5'h00, 20'h00000, 1'b1, 2'd2},
        '{1'b0, 20'h00011, 8'd3, 1'b0, 5'h00, 20'h0BBBB, 1'b1, 2'd0},
        '{1'b0, 20'h00012, 8'd3, 1'b0, 5'h00, 20'h0CCCC, 1'b1, 2'd0},
        '{1'b0, 20'h00012, 8'd3, 1'b1, 5'h00, 20'h00000, 1'b1, 2'd3},
        '{1'b0, 20'h00013, 8'd3, 1'b0, 5'h00, 20'h00000, 1'b1, 2'd1},
        '{1'b0, 20'h00013, 8'd3, 1'b1, 5'h00, 20'h00000, 1'b1, 2'd1},
        '{1'b0, 20'h00020, 8'd9, 1'b0, 5'h00, 20'h12345, 1'b1, 2'd0}, // R3 global
        '{1'b0, 20'h00020, 8'd0, 1'b1, 5'h00, 20'h12345, 1'b1, 2'd0},
        '{1'b0, 20'h00030, 8'd5, 1'b1, 5'h00, 20'h54321, 1'b1, 2'd0},
        '{1'b0, 20'h00030, 8'd3, 1'b0, 5'h00, 20'h00000, 1'b0, 2'd0},
        '{1'b0, 20'h00014, 8'd3, 1'b0, 5'h00, 20'h00000, 1'b1, 2'd2},
        '{1'b0, 20'h00014, 8'd3, 1'b1, 5'h00, 20'h0DDDD, 1'b1, 2'd0},
        '{1'b0, 20'h00099, 8'd3, 1'b0, 5'h00, 20'h00000, 1'b0, 2'd0}
    };

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic look(input logic [19:0] vpn, input logic [7:0] asid, input logic wr,
                        input logic [11:0] off, input logic ehit, input logic [1:0] eflt,
                        input logic [19:0] epfn, input string rq);
        logic [31:0] ep;
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = {vpn, off}; lk_asid = asid; lk_write = wr;
        @(negedge clk);
        lk_req = 1'b0;
        ep = (ehit && eflt == 2'd0) ? {epfn, off} : 32'h0;
        chk(rq, {27'd0, rs_valid, rs_hit, rs_miss, rs_fault, rs_paddr},
                {27'd0, 1'b1, ehit, !ehit, ehit ? eflt : 2'd0, ep});
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn,
                          input logic [4:0] fl, output logic [3:0] rnd_now);
        @(negedge clk);
        rf_we = 1'b1; rf_vpn = vpn; rf_asid = asid; rf_pfn = pfn; rf_flags = fl;
        rnd_now = lf_m;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic flush(input logic all, input logic [7:0] asid);
        @(negedge clk);
        fl_req = 1'b1; fl_all = all; fl_asid = asid;
        @(negedge clk);
        fl_req = 1'b0;
    endtask

    initial begin
        logic [3:0] s;
        logic [3:0] dummy;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs after reset", {rs_valid, rs_hit, rs_miss, rs_fault, rs_paddr}, 37'd0);
        rst = 1'b0;
        look(20'h00010, 8'd3, 1'b0, 12'h123, 1'b0, 2'd0, 20'h0, "R1 empty lookup misses");
        // R2 idle cycle
        @(negedge clk);
        chk("R2 idle gives no response", {rs_valid, rs_hit, rs_miss, rs_fault, rs_paddr}, 37'd0);

        // vector table: R3 R4 R5 R6
        for (int k = 0; k < TN; k++) begin
            if (TBL[k].op)
                refill(TBL[k].vpn, TBL[k].asid, TBL[k].pfn, TBL[k].fl, dummy);
            else
                look(TBL[k].vpn, TBL[k].asid, TBL[k].wr, 12'hABC, TBL[k].ehit, TBL[k].eflt,
                     TBL[k].pfn,
                     !TBL[k].ehit ? "R6 miss" : (TBL[k].eflt != 2'd0 ? "R5 fault" : "R4 translate"));
        end
        look(20'h00010, 8'd3, 1'b0, 12'h000, 1'b1, 2'd0, 20'h0AAAA, "R4 offset zero");
        look(20'h00010, 8'd3, 1'b0, 12'hFFF, 1'b1, 2'd0, 20'h0AAAA, "R4 offset all ones");

        // R8 random victim on a full buffer
        flush(1'b1, 8'd0);
        for (int i = 0; i < 16; i++)
            refill(20'h00200 + 20'(i), 8'd1, 20'h01000 + 20'(i), 5'h0F, dummy);
        refill(20'h00300, 8'd1, 20'h07777, 5'h0F, s);
        look(20'h00300, 8'd1, 1'b0, 12'h010, 1'b1, 2'd0, 20'h07777, "R8 new mapping present");
        for (int i = 0; i < 16; i++)
            look(20'h00200 + 20'(i), 8'd1, 1'b0, 12'h010, (4'(i) != s), 2'd0,
                 20'h01000 + 20'(i), "R8 only the shift-register slot evicted");

        // R7 overwrite of a matching slot
        refill(20'h00300, 8'd1, 20'h08888, 5'h0F, dummy);
        look(20'h00300, 8'd1, 1'b0, 12'h020, 1'b1, 2'd0, 20'h08888, "R7 overwrite in place");
        for (int i = 0; i < 16; i++)
            if (4'(i) != s)
                look(20'h00200 + 20'(i), 8'd1, 1'b0, 12'h020, 1'b1, 2'd0,
                     20'h01000 + 20'(i), "R7 overwrite evicts nothing else");

        // R9 selective flush, R7 empty slots taken before random
        flush(1'b1, 8'd0);
        for (int i = 0; i < 16; i++)
            refill(20'h00400 + 20'(i), (i % 2 == 0) ? 8'd7 : 8'd8, 20'h02000 + 20'(i),
                   (i == 0) ? 5'h1F : 5'h0F, dummy);
        flush(1'b0, 8'd7);
        look(20'h00400, 8'd7, 1'b0, 12'h0, 1'b1, 2'd0, 20'h02000, "R9 global survives asid flush");
        look(20'h00402, 8'd7, 1'b0, 12'h0, 1'b0, 2'd0, 20'h0, "R9 asid flush removes match");
        look(20'h00401, 8'd8, 1'b0, 12'h0, 1'b1, 2'd0, 20'h02001, "R9 other asid kept");
        for (int k = 0; k < 7; k++)
            refill(20'h00500 + 20'(k), 8'd9, 20'h03000 + 20'(k), 5'h0F, dummy);
        for (int i = 1; i < 16; i += 2)
            look(20'h00400 + 20'(i), 8'd8, 1'b0, 12'h0, 1'b1, 2'd0, 20'h02000 + 20'(i),
                 "R7 empty slots used before random");
        for (int k = 0; k < 7; k++)
            look(20'h00500 + 20'(k), 8'd9, 1'b0, 12'h0, 1'b1, 2'd0, 20'h03000 + 20'(k),
                 "R7 refills landed");
        look(20'h00400, 8'd7, 1'b0, 12'h0, 1'b1, 2'd0, 20'h02000, "R7 global slot kept");

        // R9 flush all clears global too
        flush(1'b1, 8'd0);
        look(20'h00400, 8'd7, 1'b0, 12'h0, 1'b0, 2'd0, 20'h0, "R9 flush all clears global");
        look(20'h00501, 8'd9, 1'b0, 12'h0, 1'b0, 2'd0, 20'h0, "R9 flush all clears rest");

        // R10 flush and refill in the same cycle
        refill(20'h00601, 8'd2, 20'h04001, 5'h0F, dummy);
        @(negedge clk);
        fl_req = 1'b1; fl_all = 1'b1;
        rf_we = 1'b1; rf_vpn = 20'h00600; rf_asid = 8'd2; rf_pfn = 20'h04000; rf_flags = 5'h0F;
        @(negedge clk);
        fl_req = 1'b0; rf_we = 1'b0;
        look(20'h00600, 8'd2, 1'b0, 12'h0, 1'b1, 2'd0, 20'h04000, "R10 refill survives flush");
        look(20'h00601, 8'd2, 1'b0, 12'h0, 1'b0, 2'd0, 20'h0, "R10 older slot flushed");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule